// File: doc/BRIEF.md
# Up-Counting Period Timer

This block is a 16-bit timer that counts upward from zero and compares its count against a period. The period is taken from compare register A at the moment counting is switched on. When the next increment would make the count equal the period, the timer pulses its interrupt for one clock and begins a fresh period at zero. It keeps counting this way until software clears the enable bit.

Software controls the timer through a small register port. Each access names an offset and a size, which is either byte or halfword. The port holds:

- a 16-bit mode register split across two byte offsets, each byte writable on its own;
- compare registers A and B;
- two capture/compare mode bytes, which are stored and read back and nothing more;
- a read-only view of the running count.

Accesses that are illegal are rejected and flagged on an error line one cycle later. Illegal means any of: a wrong size, an unmapped offset, reserved bits set, or enable and load requested together. Read data is registered and follows the read by one cycle.

Top module: `upcmp_timer`

## Requirements
- R1: After synchronous reset, every register reads zero, the timer is stopped, and rdata, err and irq are all low.
- R2: Size code 0 is a byte access and 1 is a halfword access. A byte write uses wdata[7:0] and stores it in the first mode byte at offset 0x0 or the second mode byte at offset 0x1. A halfword write at 0x0 stores wdata[15:8] in the first byte and wdata[7:0] in the second. A halfword read at 0x0 returns {first, second}. A byte read returns the addressed byte in rdata[7:0].
- R3: A mode write is rejected if it would put a one into a reserved bit. The reserved bits are bits 2, 3 and 5 of the first byte and bits 0 to 2 of the second byte. A rejected write leaves the registers unchanged, and err is high in the following cycle.
- R4: In the second mode byte, bit 7 is count enable and bit 6 is load. A write that sets both bits is rejected, with err high in the next cycle and no effect on counting.
- R5: An accepted write to the second mode byte with bit 7 set does three things: it latches compare A as the period, sets the count to 0, and starts counting. From then on the count rises by one every clock. A write with bit 7 set while already running restarts the count in the same way.
- R6: While running, when the next count would equal the period, irq is high for exactly one cycle and the count returns to 0. The first pulse comes P clocks after the starting write's clock edge, where P is the period, and the pulse then repeats every P clocks. A period of 1 gives a pulse on every clock.
- R7: Enabling with compare A equal to zero does not start the timer. The count reads 0 and irq stays low.
- R8: An accepted write of the second mode byte with bit 7 clear stops the timer at that clock edge. Afterwards the count reads 0 and no further irq occurs.
- R9: Offset 0x8 reads the count, as a halfword or as its low byte, while running, and reads 0 while stopped. A write to 0x8 is rejected with err.
- R10: Compare A (offset 0x2) and compare B (offset 0x4) accept byte and halfword accesses. A byte write stores the byte zero-extended. A byte read returns the low byte. Any other size is rejected with err and changes nothing.
- R11: The capture/compare mode bytes at 0x6 (A) and 0x7 (B) accept only byte accesses. A halfword access to either is rejected with err.
- R12: Each of the following is rejected with err: size codes 2 and 3 at any offset, a halfword access at 0x1, and any unmapped offset. rdata is 0 in every cycle that does not follow an accepted read.
- R13: Writing compare A while running does not change the current period. The new value takes effect only when counting is next started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| addr | input | 4 | Register offset |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 and 3 illegal |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, 0 when no accepted read |
| err | output | 1 | Registered pulse marking a rejected access |
| irq | output | 1 | Registered one-cycle period-match pulse |

## Verification
The hardest situation to reach is an enable write landing on the very clock edge where a period match would otherwise fire. There are two related cases: compare A being rewritten in the middle of a period, and counting being stopped. The bench keeps a behavioural model and drives sequences with exact cycle spacing: a restart timed inside a period, a compare rewrite between two matches, and a stop one cycle after a match. The model predicts irq, err and rdata on every clock, so a match that is early, late, doubled or suppressed is caught at the cycle where it happens.

// File: rtl/upcmp_pkg.sv
package upcmp_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam int OFF_MODE_LO = 0;
  localparam int OFF_MODE_HI = 1;
  localparam int OFF_CMP_A   = 2;
  localparam int OFF_CMP_B   = 4;
  localparam int OFF_CCM_A   = 6;
  localparam int OFF_CCM_B   = 7;
  localparam int OFF_COUNT   = 8;

  localparam logic [7:0] RSV_LO_MASK = 8'h2C;
  localparam logic [7:0] RSV_HI_MASK = 8'h07;
  localparam int EN_BIT = 7;
  localparam int LD_BIT = 6;
endpackage

// File: rtl/upcmp_regs.sv
module upcmp_regs
  import upcmp_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] cnt_val,
  input  logic          running,
  output logic [CW-1:0] rdata,
  output logic          err,
  output logic          start,
  output logic          stop,
  output logic [CW-1:0] period
);
  localparam int BW = CW / 2;

  logic [BW-1:0] mode_lo, mode_hi, ccm_a, ccm_b;
  logic [CW-1:0] cmp_a, cmp_b;
  logic [BW-1:0] lo_v, hi_v;
  logic [CW-1:0] wval, cnt_vis, rd_val;
  logic          we_lo, we_hi, we_ca, we_cb, we_ma, we_mb;
  logic          wr_bad, rd_bad, wr_ok, is_byte, is_half;

  assign is_byte = (size == SZ_BYTE);
  assign is_half = (size == SZ_HALF);
  assign lo_v    = is_half ? wdata[CW-1:BW] : wdata[BW-1:0];
  assign hi_v    = wdata[BW-1:0];
  assign wval    = is_byte ? {{BW{1'b0}}, wdata[BW-1:0]} : wdata;
  assign cnt_vis = running ? cnt_val : '0;

  // write decode
  always_comb begin
    wr_bad = 1'b0;
    we_lo = 1'b0; we_hi = 1'b0; we_ca = 1'b0;
    we_cb = 1'b0; we_ma = 1'b0; we_mb = 1'b0;
    case (addr)
      AW'(OFF_MODE_LO): begin
        if (is_byte) we_lo = 1'b1;
        else if (is_half) begin we_lo = 1'b1; we_hi = 1'b1; end
        else wr_bad = 1'b1;
      end
      AW'(OFF_MODE_HI): if (is_byte) we_hi = 1'b1; else wr_bad = 1'b1;
      AW'(OFF_CMP_A):   if (is_byte || is_half) we_ca = 1'b1; else wr_bad = 1'b1;
      AW'(OFF_CMP_B):   if (is_byte || is_half) we_cb = 1'b1; else wr_bad = 1'b1;
      AW'(OFF_CCM_A):   if (is_byte) we_ma = 1'b1; else wr_bad = 1'b1;
      AW'(OFF_CCM_B):   if (is_byte) we_mb = 1'b1; else wr_bad = 1'b1;
      default:          wr_bad = 1'b1;
    endcase
    if (we_lo && ((lo_v & RSV_LO_MASK) != '0)) wr_bad = 1'b1;
    if (we_hi && (((hi_v & RSV_HI_MASK) != '0) || (hi_v[EN_BIT] && hi_v[LD_BIT])))
      wr_bad = 1'b1;
  end

  // read decode
  always_comb begin
    rd_bad = 1'b0;
    rd_val = '0;
    case (addr)
      AW'(OFF_MODE_LO): begin
        if (is_byte) rd_val = {{BW{1'b0}}, mode_lo};
        else if (is_half) rd_val = {mode_lo, mode_hi};
        else rd_bad = 1'b1;
      end
      AW'(OFF_MODE_HI): if (is_byte) rd_val = {{BW{1'b0}}, mode_hi}; else rd_bad = 1'b1;
      AW'(OFF_CMP_A): begin
        if (is_byte) rd_val = {{BW{1'b0}}, cmp_a[BW-1:0]};
        else if (is_half) rd_val = cmp_a;
        else rd_bad = 1'b1;
      end
      AW'(OFF_CMP_B): begin
        if (is_byte) rd_val = {{BW{1'b0}}, cmp_b[BW-1:0]};
        else if (is_half) rd_val = cmp_b;
        else rd_bad = 1'b1;
      end
      AW'(OFF_CCM_A): if (is_byte) rd_val = {{BW{1'b0}}, ccm_a}; else rd_bad = 1'b1;
      AW'(OFF_CCM_B): if (is_byte) rd_val = {{BW{1'b0}}, ccm_b}; else rd_bad = 1'b1;
      AW'(OFF_COUNT): begin
        if (is_byte) rd_val = {{BW{1'b0}}, cnt_vis[BW-1:0]};
        else if (is_half) rd_val = cnt_vis;
        else rd_bad = 1'b1;
      end
      default: rd_bad = 1'b1;
    endcase
  end

  assign wr_ok  = wr_en && !wr_bad;
  assign start  = wr_ok && we_hi && hi_v[EN_BIT];
  assign stop   = wr_ok && we_hi && !hi_v[EN_BIT];
  assign period = cmp_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_lo <= '0; mode_hi <= '0; ccm_a <= '0; ccm_b <= '0;
      cmp_a   <= '0; cmp_b   <= '0; rdata <= '0; err   <= 1'b0;
    end else begin
      if (wr_ok && we_lo) mode_lo <= lo_v;
      if (wr_ok && we_hi) mode_hi <= hi_v;
      if (wr_ok && we_ca) cmp_a   <= wval;
      if (wr_ok && we_cb) cmp_b   <= wval;
      if (wr_ok && we_ma) ccm_a   <= wdata[BW-1:0];
      if (wr_ok && we_mb) ccm_b   <= wdata[BW-1:0];
      err   <= (wr_en && wr_bad) || (rd_en && rd_bad);
      rdata <= (rd_en && !rd_bad) ? rd_val : '0;
    end
  end

  p_mode_rsvd_clear_r3: assert property (@(posedge clk) disable iff (rst)
    ((mode_lo & RSV_LO_MASK) == '0) && ((mode_hi & RSV_HI_MASK) == '0));
  p_no_en_with_load_r4: assert property (@(posedge clk) disable iff (rst)
    !(mode_hi[EN_BIT] && mode_hi[LD_BIT]));
  p_rdata_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));
  p_wide_access_err_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && size[1]) |=> err);
endmodule

// File: rtl/upcmp_counter.sv
module upcmp_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output logic          running,
  output logic          irq
);
  logic [CW-1:0] per_q;
  logic [CW-1:0] cnt_nx;

  assign cnt_nx = cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      per_q   <= '0;
      running <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (stop) begin
        running <= 1'b0;
        cnt     <= '0;
      end else if (start) begin
        running <= (period != '0);
        per_q   <= period;
        cnt     <= '0;
      end else if (running) begin
        if (cnt_nx == per_q) begin
          cnt <= '0;
          irq <= 1'b1;
        end else begin
          cnt <= cnt_nx;
        end
      end
    end
  end

  p_below_period_r6: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt < per_q));
  p_irq_restart_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> (running && cnt == '0));
  p_zero_period_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (start && !stop && period == '0) |=> !running);
  p_stop_halts_r8: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!running && !irq && cnt == '0));
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !running |-> (cnt == '0));
endmodule

// File: rtl/upcmp_timer.sv
module upcmp_timer #(
  parameter int CW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          err,
  output logic          irq
);
  logic          start, stop, running;
  logic [CW-1:0] period, cnt;

  upcmp_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .size(size), .wdata(wdata), .cnt_val(cnt), .running(running),
    .rdata(rdata), .err(err), .start(start), .stop(stop), .period(period)
  );

  upcmp_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .period(period),
    .cnt(cnt), .running(running), .irq(irq)
  );
endmodule

// File: tb/upcmp_timer_test.sv
module upcmp_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        err, irq;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  // reference model state
  int m_lo, m_hi, m_ca, m_cb, m_ma, m_mb, m_cnt, m_per;
  bit m_run;
  int e_rd;
  bit e_err, e_irq;

  always #5 clk = ~clk;

  upcmp_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .size(size), .wdata(wdata), .rdata(rdata), .err(err), .irq(irq)
  );

  task automatic model_reset();
    m_lo = 0; m_hi = 0; m_ca = 0; m_cb = 0; m_ma = 0; m_mb = 0;
    m_cnt = 0; m_per = 0; m_run = 0; e_rd = 0; e_err = 0; e_irq = 0;
  endtask

  task automatic model_edge(bit w, bit r, int a, int s, int d);
    bit rbad, wbad, st, sp;
    int v, nlo, nhi, cv;
    rbad = 0; v = 0; cv = m_run ? m_cnt : 0;
    if (r) begin
      if (s > 1) rbad = 1;
      else if (a == 0) v = (s == 0) ? m_lo : m_lo * 256 + m_hi;
      else if (a == 1 && s == 0) v = m_hi;
      else if (a == 2) v = (s == 0) ? m_ca % 256 : m_ca;
      else if (a == 4) v = (s == 0) ? m_cb % 256 : m_cb;
      else if (a == 6 && s == 0) v = m_ma;
      else if (a == 7 && s == 0) v = m_mb;
      else if (a == 8) v = (s == 0) ? cv % 256 : cv;
      else rbad = 1;
    end
    wbad = 0; st = 0; sp = 0; nlo = -1; nhi = -1;
    if (w) begin
      if (s > 1) wbad = 1;
      else if (a == 0 && s == 0) nlo = d % 256;
      else if (a == 0) begin nlo = d / 256; nhi = d % 256; end
      else if (a == 1 && s == 0) nhi = d % 256;
      else if (a == 2 || a == 4 || ((a == 6 || a == 7) && s == 0)) wbad = 0;
      else wbad = 1;
      if (nlo >= 0 && (nlo & 'h2C) != 0) wbad = 1;
      if (nhi >= 0 && ((nhi & 'h07) != 0 || (nhi & 'hC0) == 'hC0)) wbad = 1;
    end
    e_err = (w && wbad) || (r && rbad);
    e_rd  = (r && !rbad) ? v : 0;
    e_irq = 0;
    if (w && !wbad) begin
      if (nhi >= 0) begin
        if (nhi >= 128) st = 1; else sp = 1;
      end
      if (sp) begin m_run = 0; m_cnt = 0; end
      else if (st) begin m_per = m_ca; m_run = (m_ca != 0); m_cnt = 0; end
      if (nlo >= 0) m_lo = nlo;
      if (nhi >= 0) m_hi = nhi;
      if (a == 2) m_ca = (s == 0) ? d % 256 : d;
      if (a == 4) m_cb = (s == 0) ? d % 256 : d;
      if (a == 6) m_ma = d % 256;
      if (a == 7) m_mb = d % 256;
    end
    if (!st && !sp && m_run) begin
      if (m_cnt + 1 == m_per) begin m_cnt = 0; e_irq = 1; end
      else m_cnt = m_cnt + 1;
    end
  endtask

  task automatic compare();
    checks++;
    if (rdata !== 16'(e_rd)) begin
      errors++;
      $display("FAIL %s rdata actual %h expected %h at %0t", cur_req, rdata, 16'(e_rd), $time);
    end
    checks++;
    if (err !== e_err) begin
      errors++;
      $display("FAIL %s err actual %b expected %b at %0t", cur_req, err, e_err, $time);
    end
    checks++;
    if (irq !== e_irq) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b at %0t", cur_req, irq, e_irq, $time);
    end
  endtask

  task automatic bus(bit w, bit r, int a, int s, int d);
    @(negedge clk);
    compare();
    wr_en = w; rd_en = r; addr = 4'(a); size = 2'(s); wdata = 16'(d);
    @(posedge clk);
    model_edge(w, r, a, s, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) bus(0, 0, 0, 0, 0);
  endtask

  task automatic wr(int a, int s, int d); bus(1, 0, a, s, d); endtask
  task automatic rd(int a, int s);        bus(0, 1, a, s, 0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); // idle edge, model unchanged
    // R1: reset state
    cur_req = "R1";
    rd(0, 1); rd(2, 1); rd(4, 1); rd(6, 0); rd(8, 1); idle(1);
    // R2: mode byte access
    cur_req = "R2";
    wr(0, 0, 'h41); wr(1, 0, 'h40); rd(0, 1); rd(1, 0);
    wr(0, 1, 'h1240); rd(0, 1); rd(0, 0); idle(1);
    // R3: reserved bits
    cur_req = "R3";
    wr(0, 0, 'h04); rd(0, 1); wr(1, 0, 'h01); rd(0, 1);
    wr(0, 1, 'h2000); rd(0, 1); wr(0, 0, 'h08); idle(1);
    // R4: enable with load
    cur_req = "R4";
    wr(2, 1, 3); wr(1, 0, 'hC0); rd(8, 1); idle(6);
    // R10: compare registers
    cur_req = "R10";
    wr(2, 1, 'h0005); wr(4, 0, 'h12AB); rd(4, 1); wr(2, 2, 'hFFFF);
    rd(2, 1); rd(2, 0); rd(4, 3); idle(1);
    // R11: capture/compare mode bytes
    cur_req = "R11";
    wr(6, 0, 'h5A); wr(7, 0, 'hA5); wr(6, 1, 'h1111); wr(7, 1, 1);
    rd(6, 0); rd(7, 0); rd(7, 1); idle(1);
    // R12: illegal accesses
    cur_req = "R12";
    rd(15, 1); wr(3, 0, 1); wr(1, 1, 'h0080); rd(1, 1); rd(0, 2); wr(0, 3, 0); idle(2);
    // R5 and R6: start with period 5
    cur_req = "R5";
    wr(1, 0, 'h80); rd(8, 1); rd(8, 1); rd(8, 0);
    cur_req = "R6";
    idle(12); rd(8, 1); idle(3);
    // R5: restart mid-period
    cur_req = "R5";
    wr(1, 0, 'h80); idle(7);
    // R13: compare A change while running
    cur_req = "R13";
    wr(2, 1, 3); idle(11);
    wr(1, 0, 'h80); idle(8);
    // R8: stop right after a match
    cur_req = "R8";
    idle(1); wr(1, 0, 'h00); rd(8, 1); idle(8); rd(8, 0);
    // R7: zero period
    cur_req = "R7";
    wr(2, 1, 0); wr(1, 0, 'h80); rd(8, 1); idle(6); rd(8, 1);
    // R6: period one
    cur_req = "R6";
    wr(2, 1, 1); wr(1, 0, 'h80); idle(5); rd(8, 1);
    // R9: counter access
    cur_req = "R9";
    wr(2, 1, 'h0123); wr(1, 0, 'h80); idle(100); rd(8, 1); rd(8, 0);
    wr(8, 1, 5); rd(8, 2); idle(200); rd(8, 1);
    wr(0, 1, 'h0000); rd(8, 1); idle(2);
    // R6: long period wraps back to zero
    cur_req = "R6";
    wr(1, 0, 'h80); idle(300);
    wr(1, 0, 'h00); idle(2);
    @(negedge clk); compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule